// File: doc/BRIEF.md
# I2C Serial Memory Slave Command Decoder

This block is the byte-level front end of a serial memory that answers as a slave on a two-wire I2C bus. It synchronises the raw clock and data lines to the system clock, recognises start and stop conditions, and shifts in the control byte that opens each transfer. If the control byte carries the memory's device code and its two chip-select bits match the strap inputs, the block acknowledges. It then either takes a two-byte word address and write data, or it returns stored bytes.

A 17-bit pointer addresses a parameterised byte array. Bit 16 of the pointer comes from the block-select bit of the control byte, so the array is split into two halves. Auto-increment never carries from one half into the other. The data line is open drain: the block only ever pulls it low.

Top module: `i2c_mem_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start and opens reception of a control byte. A rising SDA while SCL is high is a stop: the block returns to idle with SDA released. After reset SDA is released.
- R2: The control byte arrives MSB first. Bits [7:4] hold the device code 4'b1010, bit 3 must equal cs_strap[1], bit 2 must equal cs_strap[0], bit 1 is the block select and bit 0 is read (1) or write (0). When the code and both select bits match, the block pulls SDA low for the ninth clock.
- R3: When the control byte does not match, the block gives no acknowledge and leaves SDA released for every following byte until the next start. No memory location changes.
- R4: A write-mode control byte is followed by two address bytes, the high byte (pointer bits 15..8) first and then the low byte (bits 7..0). Each of these bytes is acknowledged.
- R5: Each data byte that follows the address bytes in a write is acknowledged and stored at the pointer. The pointer then advances by one.
- R6: Bit 1 of an accepted control byte becomes pointer bit 16. Array index = {pointer[16], pointer[AW-2:0]}, so the two halves hold independent data.
- R7: In a read the block drives each byte MSB first. It changes SDA only while SCL is low and advances the pointer after every byte.
- R8: A read-mode control byte that follows a repeated start after the address bytes returns data from the captured address. A read-mode control byte on its own returns data from the current pointer.
- R9: When a read or write advances the pointer past 0xFFFF in its lower 16 bits, those bits wrap to 0x0000 and bit 16 stays unchanged.
- R10: When the master does not acknowledge a read byte, the block releases SDA and stays silent, without acknowledging, until the next start.
- R11: A start in the middle of a byte abandons that byte and restarts control-byte reception with a cleared bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line, as seen on the wire |
| cs_strap | input | 2 | Chip-select straps; [1] is compared with control bit 3, [0] with control bit 2 |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench writes across the 0xFFFF boundary in one half and reads it back. A design that carried into bit 16 would overwrite, and then return, the byte stored at address 0 of the other half. It also reads the same low address in both halves, which a design that ignored the block-select bit would confuse. It sends control bytes with wrong select bits and a wrong device code, followed by address and data bytes. A design that answered those bytes would acknowledge them or corrupt a stored byte. Other stimulus covers clocking a byte after a master NACK with no start, and a start a few bits into a byte. After a NACK, a leaky design would acknowledge the extra byte. After the early start, a design that kept its bit count would misalign the next control byte and reject it.

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int MEM_DEPTH = 512,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] cs_strap,
  output logic       sda_pull
);
  localparam int AW = $clog2(MEM_DEPTH);
  localparam int LW = AW - 1;

  typedef enum logic [2:0] {ST_IDLE, ST_CTRL, ST_AHI, ST_ALO, ST_WDAT, ST_READ} st_t;

  logic [2:0] scl_sr, sda_sr;
  logic       scl_s, scl_q, sda_s, sda_q;
  logic       start_ev, stop_ev, rise, fall;
  st_t        state, nxt;
  logic [3:0] cnt;
  logic [7:0] sreg;
  logic [6:0] txreg;
  logic [16:0] ptr;
  logic       mack;
  logic [7:0] mem [MEM_DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[1:0], scl_in};
      sda_sr <= {sda_sr[1:0], sda_in};
    end

  assign scl_s = scl_sr[1];
  assign scl_q = scl_sr[2];
  assign sda_s = sda_sr[1];
  assign sda_q = sda_sr[2];

  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise     = scl_s & ~scl_q;
  assign fall     = ~scl_s & scl_q;

  wire          rx      = state inside {ST_CTRL, ST_AHI, ST_ALO, ST_WDAT};
  wire          ctrl_ok = (sreg[7:4] == DEV_CODE) && (sreg[3:2] == cs_strap);
  wire [AW-1:0] idx     = {ptr[16], ptr[LW-1:0]};
  wire [7:0]    rd_byte = mem[idx];
  wire [16:0]   ptr_inc = {ptr[16], ptr[15:0] + 16'd1};

  always_ff @(posedge clk)
    if (!start_ev && !stop_ev && fall && cnt == 4'd8 && state == ST_WDAT)
      mem[idx] <= sreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= ST_IDLE;
      nxt      <= ST_IDLE;
      cnt      <= '0;
      sreg     <= '0;
      txreg    <= '0;
      ptr      <= '0;
      mack     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_ev) begin
      state    <= ST_CTRL;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (stop_ev) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (rise) begin
        if (cnt < 4'd8) begin
          if (rx) sreg <= {sreg[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end else if (cnt == 4'd8) begin
          mack <= ~sda_s;
          cnt  <= 4'd9;
        end
      end else if (fall) begin
        if (state == ST_READ && cnt != 4'd0 && cnt < 4'd8) begin
          sda_pull <= ~txreg[6];
          txreg    <= {txreg[5:0], 1'b0};
        end else if (cnt == 4'd8) begin
          case (state)
            ST_CTRL:
              if (ctrl_ok) begin
                sda_pull <= 1'b1;
                ptr[16]  <= sreg[1];
                nxt      <= sreg[0] ? ST_READ : ST_AHI;
              end else begin
                state <= ST_IDLE;
                cnt   <= '0;
              end
            ST_AHI: begin
              ptr[15:8] <= sreg;
              sda_pull  <= 1'b1;
              nxt       <= ST_ALO;
            end
            ST_ALO: begin
              ptr[7:0] <= sreg;
              sda_pull <= 1'b1;
              nxt      <= ST_WDAT;
            end
            ST_WDAT: begin
              ptr      <= ptr_inc;
              sda_pull <= 1'b1;
              nxt      <= ST_WDAT;
            end
            ST_READ: begin
              ptr      <= ptr_inc;
              sda_pull <= 1'b0;
            end
            default: ;
          endcase
        end else if (cnt == 4'd9) begin
          cnt <= '0;
          if (rx) begin
            state <= nxt;
            if (nxt == ST_READ) begin
              txreg    <= rd_byte[6:0];
              sda_pull <= ~rd_byte[7];
            end else begin
              sda_pull <= 1'b0;
            end
          end else if (mack) begin
            txreg    <= rd_byte[6:0];
            sda_pull <= ~rd_byte[7];
          end else begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
          end
        end
      end
    end

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE && !sda_pull));

  // R11
  start_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == ST_CTRL && cnt == 4'd0));

  // R7
  sda_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q && !start_ev && !stop_ev) |=> (sda_pull == $past(sda_pull)));

  // R9
  segment_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_CTRL) |=> $stable(ptr[16]));

  // R3
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull);
endmodule

// File: tb/sim_i2c_mem_slave.sv
module sim_i2c_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 3;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] cs = 2'b10;
  logic sda_pull;
  wire  sda_bus = sda_m & ~sda_pull;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] got_byte;
  event got_ev;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .cs_strap(cs), .sda_pull(sda_pull)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wait_n(H);
    scl_m = 1'b1; wait_n(H);
    sda_m = 1'b0; wait_n(H);
    scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    wait_n(Q); sda_m = 1'b0; wait_n(H);
    scl_m = 1'b1; wait_n(H);
    sda_m = 1'b1; wait_n(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      wait_n(Q); sda_m = b[i]; wait_n(Q);
      scl_m = 1'b1; wait_n(H); scl_m = 1'b0;
    end
  endtask

  task automatic wb(input logic [7:0] b, input bit exp_ack, input string req);
    bit a;
    send_bits(b, 8);
    wait_n(Q); sda_m = 1'b1; wait_n(Q);
    scl_m = 1'b1; wait_n(Q); a = ~sda_bus; wait_n(Q); scl_m = 1'b0;
    check(a == exp_ack, req, "ack after byte", int'(a), int'(exp_ack));
  endtask

  task automatic rb(input bit give_ack, input logic [7:0] exp, input string req);
    logic [7:0] v;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_n(H); scl_m = 1'b1; wait_n(Q); v[i] = sda_bus; wait_n(Q); scl_m = 1'b0;
    end
    wait_n(Q); sda_m = ~give_ack; wait_n(Q);
    scl_m = 1'b1; wait_n(H); scl_m = 1'b0;
    wait_n(Q); sda_m = 1'b1;
    got_byte = v;
    -> got_ev;
  endtask

  task automatic rand_read_setup(input logic [7:0] ctl, input logic [7:0] hi, input logic [7:0] lo, input string req);
    i2c_start(); wb(ctl, 1, req); wb(hi, 1, req); wb(lo, 1, req);
    i2c_start(); wb(ctl | 8'h01, 1, req);
  endtask

  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) begin
        check(0, "R7", "unexpected read byte", int'(got_byte), 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got_byte == e, t, "read data", int'(got_byte), int'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_n(5); rst_n = 1'b1; wait_n(5);
    // R1: released after reset
    check(sda_pull == 1'b0, "R1", "sda after reset", int'(sda_pull), 0);

    // R2 R4 R5: write three bytes at 0x1234 in half 0
    i2c_start(); wb(8'hA8, 1, "R2"); wb(8'h12, 1, "R4"); wb(8'h34, 1, "R4");
    wb(8'h5A, 1, "R5"); wb(8'hC3, 1, "R5"); wb(8'h77, 1, "R5");
    i2c_stop();
    check(sda_pull == 1'b0, "R1", "sda after stop", int'(sda_pull), 0);

    // R8 R7: random read of two bytes
    rand_read_setup(8'hA8, 8'h12, 8'h34, "R8");
    rb(1, 8'h5A, "R8"); rb(0, 8'hC3, "R7");
    i2c_stop();

    // R8: current-address read, then R10 silence after NACK
    i2c_start(); wb(8'hA9, 1, "R8"); rb(0, 8'h77, "R8");
    wait_n(2);
    check(sda_pull == 1'b0, "R10", "sda after nack", int'(sda_pull), 0);
    wb(8'hA8, 0, "R10");
    i2c_stop();

    // R6: same low address in half 1
    i2c_start(); wb(8'hAA, 1, "R6"); wb(8'h12, 1, "R6"); wb(8'h34, 1, "R6");
    wb(8'h99, 1, "R6"); i2c_stop();
    rand_read_setup(8'hA8, 8'h12, 8'h34, "R6"); rb(0, 8'h5A, "R6"); i2c_stop();
    rand_read_setup(8'hAA, 8'h12, 8'h34, "R6"); rb(0, 8'h99, "R6"); i2c_stop();

    // R9: wrap inside half 1 leaves half 0 address 0 intact
    i2c_start(); wb(8'hA8, 1, "R9"); wb(8'h00, 1, "R9"); wb(8'h00, 1, "R9");
    wb(8'hEE, 1, "R9"); i2c_stop();
    i2c_start(); wb(8'hAA, 1, "R9"); wb(8'hFF, 1, "R9"); wb(8'hFF, 1, "R9");
    wb(8'h11, 1, "R9"); wb(8'h22, 1, "R9"); i2c_stop();
    rand_read_setup(8'hAA, 8'hFF, 8'hFF, "R9"); rb(1, 8'h11, "R9"); rb(0, 8'h22, "R9"); i2c_stop();
    rand_read_setup(8'hA8, 8'h00, 8'h00, "R9"); rb(0, 8'hEE, "R9"); i2c_stop();

    // R3: wrong select bits, then wrong device code
    i2c_start(); wb(8'hA4, 0, "R3"); wb(8'h12, 0, "R3"); wb(8'h34, 0, "R3");
    wb(8'h00, 0, "R3"); i2c_stop();
    i2c_start(); wb(8'hB8, 0, "R2"); i2c_stop();
    rand_read_setup(8'hA8, 8'h12, 8'h34, "R3"); rb(0, 8'h5A, "R3"); i2c_stop();

    // R11: start three bits into a byte
    i2c_start(); send_bits(8'hA0, 3);
    i2c_start(); wb(8'hA8, 1, "R11"); wb(8'h12, 1, "R11"); wb(8'h35, 1, "R11");
    i2c_start(); wb(8'hA9, 1, "R11"); rb(0, 8'hC3, "R11"); i2c_stop();

    // R2: opposite strap pattern
    cs = 2'b01; wait_n(2);
    i2c_start(); wb(8'hA4, 1, "R2"); i2c_stop();
    i2c_start(); wb(8'hA8, 0, "R2"); i2c_stop();

    wait_n(10);
    check(exp_q.size() == 0, "R7", "pending read items", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule